// File: doc/BRIEF.md
# Pulse-Frequency Buck Switch Sequencer

This block is the digital sequencer behind a buck converter that runs in pulse-frequency mode. Three comparator flags come in from the analog side: the output sits below the upper regulation threshold, the inductor current has passed the peak limit, and the inductor current has fallen to zero. From these flags the block drives the gate enables of the high-side PMOS and the low-side NMOS.

Each energy packet is a charge phase followed by a discharge phase. During charge the high-side switch is on. Charge ends when the output reaches the threshold or when the peak limit trips, whichever happens first. During discharge the low-side switch is on until the zero-current flag arrives. If the output is still low at that point, another packet follows. If it is not, the converter parks with both switches off and reports sleep until the output droops again.

A fixed number of dead cycles, with both switches off, separates every hand-over between the two switches. A timeout bounds the discharge phase in case the zero-current flag never arrives. Dropping the enable input turns both gates off in the same cycle.

Top module: `pfm_switch_ctrl`

## Requirements
- R1: After reset, and while the block is disabled, `hs_on`, `ls_on` and `sleep` are all 0.
- R2: When `en` and `below_hi` are both 1 while the block is idle, `hs_on` rises after exactly DEAD_CYC both-off cycles. With the reset default of 3 this is on the 4th rising edge.
- R3: While `hs_on` is 1, a sampled `peak_over`=1 or `below_hi`=0 makes `hs_on` 0 from the next cycle on.
- R4: Every rising edge of `hs_on` or `ls_on` is preceded by at least DEAD_CYC cycles in which both gates are 0. After a charge phase ends, `ls_on` rises after exactly DEAD_CYC cycles.
- R5: `ls_on` stays 1 until `zero_i` is sampled as 1. It then drops in the next cycle. If `below_hi` was 1 at that edge, `hs_on` rises after DEAD_CYC further cycles.
- R6: If `zero_i` ends a discharge while `below_hi` is 0, both gates go off and `sleep` becomes 1 in the next cycle.
- R7: `sleep` holds as long as `below_hi` stays 0. A sampled `below_hi`=1 clears `sleep` in the next cycle, and `hs_on` rises DEAD_CYC cycles later.
- R8: `en`=0 forces `hs_on`, `ls_on` and `sleep` to 0 in the same cycle. The sequencer restarts from idle when `en` returns.
- R9: `ls_on` is never 1 for more than ZC_TIMEOUT consecutive cycles. Without `zero_i`, the discharge ends after exactly ZC_TIMEOUT cycles and then follows the R5/R6 choice.
- R10: `hs_on` and `ls_on` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Converter enable |
| below_hi | input | 1 | Output is below the upper regulation threshold |
| peak_over | input | 1 | Inductor current is above the peak limit |
| zero_i | input | 1 | Inductor current has reached zero |
| hs_on | output | 1 | High-side PMOS gate enable |
| ls_on | output | 1 | Low-side NMOS gate enable |
| sleep | output | 1 | Both switches parked off, waiting for the output to droop |

## Verification
The hardest case to reach is the discharge timeout. Random comparator flags almost always deliver `zero_i` long before the limit. A directed sequence therefore holds `zero_i` low through one entire discharge and checks the exact cycle in which `ls_on` falls. The random phase runs with a reduced timeout and a low `zero_i` rate, so that timeouts and flags arriving in the same cycle as the timeout also occur. Every cycle of that phase is compared against a cycle-level reference model kept in the bench.

// File: rtl/pfm_switch_ctrl.sv
module pfm_switch_ctrl #(
  parameter int DEAD_CYC   = 3,
  parameter int ZC_TIMEOUT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic below_hi,
  input  logic peak_over,
  input  logic zero_i,
  output logic hs_on,
  output logic ls_on,
  output logic sleep
);
  localparam int DW = $clog2(DEAD_CYC + 1) + 1;
  localparam int WW = $clog2(ZC_TIMEOUT + 1) + 1;

  typedef enum logic [2:0] {S_IDLE, S_GAP_LH, S_CHG, S_GAP_HL, S_DIS, S_SLEEP} st_t;

  st_t           st;
  logic [DW-1:0] dt_cnt;
  logic [WW-1:0] wd_cnt;

  wire dt_done = (dt_cnt == DW'(DEAD_CYC - 1));
  wire dis_end = zero_i || (wd_cnt == WW'(ZC_TIMEOUT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      st     <= S_IDLE;
      dt_cnt <= '0;
      wd_cnt <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          dt_cnt <= '0;
          st     <= below_hi ? S_GAP_LH : S_SLEEP;
        end
        S_SLEEP: if (below_hi) begin
          dt_cnt <= '0;
          st     <= S_GAP_LH;
        end
        S_GAP_LH: begin
          if (dt_done) st <= S_CHG;
          else dt_cnt <= dt_cnt + 1'b1;
        end
        S_CHG: if (peak_over || !below_hi) begin
          dt_cnt <= '0;
          st     <= S_GAP_HL;
        end
        S_GAP_HL: begin
          if (dt_done) begin
            wd_cnt <= '0;
            st     <= S_DIS;
          end else dt_cnt <= dt_cnt + 1'b1;
        end
        S_DIS: begin
          if (dis_end) begin
            dt_cnt <= '0;
            st     <= below_hi ? S_GAP_LH : S_SLEEP;
          end else wd_cnt <= wd_cnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign hs_on = en && (st == S_CHG);
  assign ls_on = en && (st == S_DIS);
  assign sleep = en && (st == S_SLEEP);

  localparam int GW = $clog2(DEAD_CYC + 1) + 1;
  logic [GW-1:0] gap;
  logic [WW-1:0] ls_run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap    <= '0;
      ls_run <= '0;
    end else begin
      if (hs_on || ls_on) gap <= '0;
      else if (gap < GW'(DEAD_CYC)) gap <= gap + 1'b1;
      if (!ls_on) ls_run <= '0;
      else if (ls_run < WW'(ZC_TIMEOUT)) ls_run <= ls_run + 1'b1;
    end
  end

  assert_no_overlap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_on && ls_on));

  assert_dead_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(hs_on) || $rose(ls_on)) |-> gap >= GW'(DEAD_CYC));

  assert_charge_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_on && (peak_over || !below_hi)) |=> !hs_on);

  assert_zero_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ls_on && zero_i) |=> !ls_on);

  assert_dis_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ls_on |-> ls_run < WW'(ZC_TIMEOUT));

  assert_sleep_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep && !below_hi && en) |=> (sleep || !en));

  assert_disable_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!hs_on && !ls_on && !sleep));
endmodule

// File: tb/pfm_switch_ctrl_test.sv
module pfm_switch_ctrl_test;
  localparam int D = 2;
  localparam int T = 16;

  logic clk = 0, rst_n = 0, en = 0, below_hi = 0, peak_over = 0, zero_i = 0;
  logic hs_on, ls_on, sleep;
  int tests = 0, fails = 0;
  bit done = 0;

  pfm_switch_ctrl #(.DEAD_CYC(D), .ZC_TIMEOUT(T)) uut (
    .clk(clk), .rst_n(rst_n), .en(en), .below_hi(below_hi),
    .peak_over(peak_over), .zero_i(zero_i),
    .hs_on(hs_on), .ls_on(ls_on), .sleep(sleep));

  always #10 clk = ~clk;

  task automatic chk(string r, logic [2:0] got, logic [2:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got hs/ls/sleep=%b exp %b", r, got, exp);
    end
  endtask

  // reference model: 0 idle, 1 gap before charge, 2 charge, 3 gap before discharge, 4 discharge, 5 sleep
  int m = 0, mdt = 0, mwd = 0;
  bit model_on = 0;

  function automatic logic [2:0] exp_out(int s, logic e);
    return {e && s == 2, e && s == 4, e && s == 5};
  endfunction

  always @(posedge clk) begin
    if (!rst_n || !en) begin m = 0; mdt = 0; mwd = 0; end
    else case (m)
      0: begin mdt = 0; m = below_hi ? 1 : 5; end
      5: if (below_hi) begin mdt = 0; m = 1; end
      1: if (mdt == D-1) m = 2; else mdt++;
      2: if (peak_over || !below_hi) begin mdt = 0; m = 3; end
      3: if (mdt == D-1) begin mwd = 0; m = 4; end else mdt++;
      4: if (zero_i || mwd == T-1) begin mdt = 0; m = below_hi ? 1 : 5; end else mwd++;
      default: m = 0;
    endcase
    #8;
    if (model_on) begin
      chk("R10 model", {hs_on, ls_on, sleep}, exp_out(m, en));
      if (hs_on && ls_on) chk("R10 overlap", 3'b110, 3'b000);
    end
  end

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: run hung");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    tick(3);
    chk("R1 reset", {hs_on, ls_on, sleep}, 3'b000);
    rst_n = 1;
    tick();
    chk("R1 disabled", {hs_on, ls_on, sleep}, 3'b000);
    en = 1; below_hi = 1;
    tick(2);
    chk("R2 still in gap", {hs_on, ls_on, sleep}, 3'b000);
    tick();
    chk("R2 charge on", {hs_on, ls_on, sleep}, 3'b100);
    peak_over = 1;
    tick();
    peak_over = 0;
    chk("R3 peak ends charge", {hs_on, ls_on, sleep}, 3'b000);
    tick();
    chk("R4 dead gap", {hs_on, ls_on, sleep}, 3'b000);
    tick();
    chk("R4 discharge on", {hs_on, ls_on, sleep}, 3'b010);
    tick(3);
    chk("R5 waits for zero", {hs_on, ls_on, sleep}, 3'b010);
    zero_i = 1;
    tick();
    zero_i = 0;
    chk("R5 zero ends discharge", {hs_on, ls_on, sleep}, 3'b000);
    tick();
    chk("R4 gap before recharge", {hs_on, ls_on, sleep}, 3'b000);
    tick();
    chk("R5 new charge pulse", {hs_on, ls_on, sleep}, 3'b100);
    below_hi = 0;
    tick();
    chk("R3 threshold ends charge", {hs_on, ls_on, sleep}, 3'b000);
    tick(2);
    chk("R6 final discharge", {hs_on, ls_on, sleep}, 3'b010);
    zero_i = 1;
    tick();
    zero_i = 0;
    chk("R6 sleep entered", {hs_on, ls_on, sleep}, 3'b001);
    tick(5);
    chk("R7 sleep held", {hs_on, ls_on, sleep}, 3'b001);
    below_hi = 1;
    tick();
    chk("R7 sleep left", {hs_on, ls_on, sleep}, 3'b000);
    tick(2);
    chk("R7 charge after wake", {hs_on, ls_on, sleep}, 3'b100);
    en = 0;
    #1;
    chk("R8 immediate off", {hs_on, ls_on, sleep}, 3'b000);
    tick(2);
    chk("R8 stays idle", {hs_on, ls_on, sleep}, 3'b000);
    en = 1;
    tick(3);
    chk("R8 restart", {hs_on, ls_on, sleep}, 3'b100);
    peak_over = 1;
    tick();
    peak_over = 0;
    tick(2);
    chk("R9 discharge start", {hs_on, ls_on, sleep}, 3'b010);
    tick(T - 1);
    chk("R9 last discharge cycle", {hs_on, ls_on, sleep}, 3'b010);
    tick();
    chk("R9 timeout forces off", {hs_on, ls_on, sleep}, 3'b000);

    en = 0; tick(); en = 1;
    model_on = 1;
    for (int i = 0; i < 4000; i++) begin
      en        = ($urandom % 100) >= 2;
      below_hi  = ($urandom % 100) < 70;
      peak_over = ($urandom % 100) < 10;
      zero_i    = ($urandom % 100) < 6;
      tick();
    end
    tick();
    model_on = 0;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule